// File: doc/BRIEF.md
# Accumulator Shift, Negate and Multiply Unit

This block is the arithmetic slice of a small accumulator CPU that handles the single-byte shift and rotate operations, two's-complement negate, inclusive OR, nibble swap and the unsigned 8x8 multiply. The sequencer presents an opcode, the accumulator, the index low byte, an already fetched memory operand and the current condition flags. The block decodes the opcode. Within the same cycle it returns the new accumulator and index values.

The block also forms the next condition flags. They are captured in a flag register at the clock edge on which `exec` is high. Each operation has its own flag rule:

- Some operations set flags from the result.
- Some operations force flags to zero.
- Nibble swap passes all flags through unchanged.
- Multiply writes its 16-bit product across both data registers.

Operand fetch, addressing and multi-cycle sequencing are handled elsewhere.

Top module: `acc_shift_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first executed operation, `ccr_q` reads 0. The flag bit layout used by `ccr_in` and `ccr_q` is [4]=V, [3]=H, [2]=N, [1]=Z, [0]=C.
- R2: Opcode 0x42 (multiply) forms the 16-bit product of index and accumulator. The high byte goes to `idx_out` and the low byte to `acc_out`. H and C are cleared, and V, N and Z are copied from `ccr_in`.
- R3: Opcode 0x62 (nibble swap) exchanges the upper and lower halves of the accumulator. All five flags equal `ccr_in`.
- R4: Opcodes 0x40 (accumulator) and 0x50 (index) negate the operand as 0x00 minus the operand. C is set when the result is nonzero. V is set only when the operand is 0x80. H is kept.
- R5: Opcodes 0x44 (accumulator) and 0x54 (index) shift right logically. A zero enters bit 7, bit 0 goes to C, N is cleared, and V equals C. H is kept.
- R6: Opcodes 0x48 (accumulator) and 0x58 (index) shift left logically. A zero enters bit 0, bit 7 goes to C, and V is N xor C. H is kept.
- R7: Opcodes 0x49 (accumulator) and 0x59 (index) rotate left through carry. The incoming C enters bit 0, bit 7 goes to C, and V is N xor C. H is kept.
- R8: Opcode 0xAA writes accumulator OR memory operand to the accumulator. V is cleared, while H and C are kept.
- R9: For negate, shift, rotate and OR, N copies bit 7 of the result and Z is set exactly when the result is 0x00.
- R10: Any other opcode drives `known` low and passes the accumulator and index through unchanged. Its flag capture equals `ccr_in`.
- R11: Operations that target one register leave the other register output equal to its input.
- R12: With `exec` low, `ccr_q` holds its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Capture the next flags at this clock edge |
| opcode | input | 8 | Operation code |
| acc_in | input | DW | Accumulator value |
| idx_in | input | DW | Index low byte value |
| mem_in | input | DW | Memory operand for OR |
| ccr_in | input | 5 | Current flags {V,H,N,Z,C} |
| acc_out | output | DW | New accumulator value |
| idx_out | output | DW | New index value |
| known | output | 1 | Opcode is one the block handles |
| ccr_q | output | 5 | Registered flags {V,H,N,Z,C} |

## Verification
The bench builds the block with the default width `DW`=8. At this width the whole operand space stays small. Multiply is swept over all 65,536 index and accumulator pairs, and every single-operand operation is swept over all 256 values with both carry-in levels. The OR sweep covers every accumulator value against a dense stride of memory values. This brings the corner operands within reach: 0x80 and 0x00 for negate, and the full-scale product 0xFE01.

// File: rtl/acc_shift_unit.sv
module acc_shift_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] idx_in,
  input  logic [DW-1:0] mem_in,
  input  logic [4:0]    ccr_in,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] idx_out,
  output logic          known,
  output logic [4:0]    ccr_q
);
  localparam int PW = 2 * DW;
  localparam int HW = DW / 2;
  localparam int VB = 4, HB = 3, NB = 2, ZB = 1, CB = 0;

  typedef enum logic [2:0] {K_NONE, K_NEG, K_LSR, K_LSL, K_ROL, K_ORA, K_NSA, K_MUL} kind_t;

  kind_t         kind;
  logic          use_x;
  logic [DW-1:0] src, res;
  logic [PW-1:0] prod;
  logic [4:0]    nxt;

  always_comb begin
    kind  = K_NONE;
    use_x = 1'b0;
    case (opcode)
      8'h40: kind = K_NEG;
      8'h50: begin kind = K_NEG; use_x = 1'b1; end
      8'h44: kind = K_LSR;
      8'h54: begin kind = K_LSR; use_x = 1'b1; end
      8'h48: kind = K_LSL;
      8'h58: begin kind = K_LSL; use_x = 1'b1; end
      8'h49: kind = K_ROL;
      8'h59: begin kind = K_ROL; use_x = 1'b1; end
      8'hAA: kind = K_ORA;
      8'h62: kind = K_NSA;
      8'h42: kind = K_MUL;
      default: kind = K_NONE;
    endcase
  end

  assign src  = use_x ? idx_in : acc_in;
  assign prod = PW'(idx_in) * PW'(acc_in);

  always_comb begin
    res = src;
    nxt = ccr_in;
    case (kind)
      K_NEG: begin
        res     = '0 - src;
        nxt[CB] = |res;
        nxt[VB] = (src == {1'b1, {(DW-1){1'b0}}});
      end
      K_LSR: begin
        res     = {1'b0, src[DW-1:1]};
        nxt[CB] = src[0];
      end
      K_LSL: begin
        res     = {src[DW-2:0], 1'b0};
        nxt[CB] = src[DW-1];
      end
      K_ROL: begin
        res     = {src[DW-2:0], ccr_in[CB]};
        nxt[CB] = src[DW-1];
      end
      K_ORA: begin
        res     = acc_in | mem_in;
        nxt[VB] = 1'b0;
      end
      K_NSA: res = {src[HW-1:0], src[DW-1:HW]};
      K_MUL: begin
        nxt[HB] = 1'b0;
        nxt[CB] = 1'b0;
      end
      default: ;
    endcase
    if (kind inside {K_NEG, K_LSR, K_LSL, K_ROL, K_ORA}) begin
      nxt[NB] = res[DW-1];
      nxt[ZB] = ~|res;
    end
    if (kind inside {K_LSR, K_LSL, K_ROL})
      nxt[VB] = nxt[NB] ^ nxt[CB];
  end

  assign known   = (kind != K_NONE);
  assign acc_out = (kind == K_MUL) ? prod[DW-1:0] :
                   (known && !use_x) ? res : acc_in;
  assign idx_out = (kind == K_MUL) ? prod[PW-1:DW] :
                   use_x ? res : idx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ccr_q <= '0;
    else if (exec) ccr_q <= nxt;
  end

  // R2
  mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode == 8'h42) |=> (ccr_q[HB] == 1'b0 && ccr_q[CB] == 1'b0 &&
      ccr_q[VB] == $past(ccr_in[VB]) && ccr_q[NB] == $past(ccr_in[NB]) &&
      ccr_q[ZB] == $past(ccr_in[ZB])));

  // R3
  nsa_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode == 8'h62) |=> (ccr_q == $past(ccr_in)));

  // R5
  lsr_n_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (opcode == 8'h44 || opcode == 8'h54)) |=> !ccr_q[NB]);

  // R6
  shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (opcode == 8'h48 || opcode == 8'h58 || opcode == 8'h49 || opcode == 8'h59))
      |=> (ccr_q[VB] == (ccr_q[NB] ^ ccr_q[CB])));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode == 8'hAA) |=> (ccr_q[ZB] == ($past(acc_out) == '0)));

  // R10
  unknown_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !known) |=> (ccr_q == $past(ccr_in)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(ccr_q));
endmodule

// File: tb/sim_acc_shift_unit.sv
`timescale 1ns/1ps
module sim_acc_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [7:0] opcode = 8'h00, acc_in = 8'h00, idx_in = 8'h00, mem_in = 8'h00;
  logic [4:0] ccr_in = 5'h00;
  logic [7:0] acc_out, idx_out;
  logic       known;
  logic [4:0] ccr_q;
  int total = 0, bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  acc_shift_unit #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .exec(exec), .opcode(opcode),
    .acc_in(acc_in), .idx_in(idx_in), .mem_in(mem_in), .ccr_in(ccr_in),
    .acc_out(acc_out), .idx_out(idx_out), .known(known), .ccr_q(ccr_q));

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] op, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] m, input logic [4:0] f,
                         input logic [7:0] ea, input logic [7:0] ex, input logic [4:0] ef,
                         input logic ek, input string tag);
    @(negedge clk);
    exec = 1'b1; opcode = op; acc_in = a; idx_in = x; mem_in = m; ccr_in = f;
    #1;
    chk({tag, " acc"}, acc_out, ea);
    chk({tag, " idx"}, idx_out, ex);
    chk({tag, " known"}, known, ek);
    @(posedge clk);
    #1;
    chk({tag, " flags"}, ccr_q, ef);
  endtask

  function automatic logic [4:0] fl(input bit v, input bit h, input bit n, input bit z, input bit c);
    return {v, h, n, z, c};
  endfunction

  initial begin
    #(180000 * 5);
    if (!ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flags", ccr_q, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", ccr_q, 0);

    // R2: multiply, full sweep
    for (int x = 0; x < 256; x++) begin
      for (int a = 0; a < 256; a++) begin
        int p;
        logic [4:0] f;
        p = x * a;
        f = 5'((x + a * 3) & 31);
        run_vec(8'h42, 8'(a), 8'(x), 8'h00, f, 8'(p % 256), 8'(p / 256),
                fl(f[4], 1'b0, f[2], f[1], 1'b0), 1'b1, "R2 mul");
      end
    end

    for (int s = 0; s < 256; s++) begin
      for (int ci = 0; ci < 2; ci++) begin
        logic [4:0] f;
        int r;
        bit n, z, c;
        f = 5'(((s * 5) & 30) | ci);
        // R3: nibble swap
        run_vec(8'h62, 8'(s), 8'h3C, 8'h00, f, 8'(((s % 16) * 16) + (s / 16)), 8'h3C, f, 1'b1, "R3 nsa");
        // R4/R9/R11: negate
        r = (256 - s) % 256; n = (r >= 128); z = (r == 0);
        run_vec(8'h40, 8'(s), 8'h5A, 8'h00, f, 8'(r), 8'h5A,
                fl(s == 128, f[3], n, z, r != 0), 1'b1, "R4 nega");
        run_vec(8'h50, 8'hA5, 8'(s), 8'h00, f, 8'hA5, 8'(r),
                fl(s == 128, f[3], n, z, r != 0), 1'b1, "R4 negx R11");
        // R5: shift right
        r = s / 2; c = s % 2; z = (r == 0);
        run_vec(8'h44, 8'(s), 8'h11, 8'h00, f, 8'(r), 8'h11, fl(c, f[3], 1'b0, z, c), 1'b1, "R5 lsra");
        run_vec(8'h54, 8'h22, 8'(s), 8'h00, f, 8'h22, 8'(r), fl(c, f[3], 1'b0, z, c), 1'b1, "R5 lsrx R11");
        // R6: shift left
        r = (s * 2) % 256; c = (s >= 128); n = (r >= 128); z = (r == 0);
        run_vec(8'h48, 8'(s), 8'h33, 8'h00, f, 8'(r), 8'h33, fl(n ^ c, f[3], n, z, c), 1'b1, "R6 lsla");
        run_vec(8'h58, 8'h44, 8'(s), 8'h00, f, 8'h44, 8'(r), fl(n ^ c, f[3], n, z, c), 1'b1, "R6 lslx R11");
        // R7: rotate left through carry
        r = (s * 2) % 256 + ci; n = (r >= 128); z = (r == 0);
        run_vec(8'h49, 8'(s), 8'h66, 8'h00, f, 8'(r), 8'h66, fl(n ^ c, f[3], n, z, c), 1'b1, "R7 rola");
        run_vec(8'h59, 8'h77, 8'(s), 8'h00, f, 8'h77, 8'(r), fl(n ^ c, f[3], n, z, c), 1'b1, "R7 rolx R11");
      end
    end

    // R8/R9: inclusive OR
    for (int a = 0; a < 256; a++) begin
      for (int m = 0; m < 256; m += 3) begin
        logic [4:0] f;
        logic [7:0] r;
        f = 5'((a ^ m) & 31);
        r = 8'(a) | 8'(m);
        run_vec(8'hAA, 8'(a), 8'h99, 8'(m), f, r, 8'h99,
                fl(1'b0, f[3], r[7], r == 0, f[0]), 1'b1, "R8 ora R9");
      end
    end
    run_vec(8'hAA, 8'h00, 8'h12, 8'h00, 5'h1F, 8'h00, 8'h12, 5'b01011, 1'b1, "R9 ora zero");

    // R10: unknown opcodes
    run_vec(8'h41, 8'h81, 8'h7E, 8'hFF, 5'h15, 8'h81, 8'h7E, 5'h15, 1'b0, "R10 op41");
    run_vec(8'h00, 8'h01, 8'h02, 8'h03, 5'h0A, 8'h01, 8'h02, 5'h0A, 1'b0, "R10 op00");
    run_vec(8'hFF, 8'hF0, 8'h0F, 8'h55, 5'h1F, 8'hF0, 8'h0F, 5'h1F, 1'b0, "R10 opFF");

    // R12: exec low holds flags
    run_vec(8'h40, 8'h80, 8'h00, 8'h00, 5'h00, 8'h80, 8'h00, 5'b10101, 1'b1, "R12 setup");
    @(negedge clk);
    exec = 1'b0; opcode = 8'h40; acc_in = 8'h00; ccr_in = 5'h0A;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 hold", ccr_q, 5'b10101);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule